// File: doc/BRIEF.md
# Priority-Based Reference Source Selector

This block chooses which of several candidate timing references a downstream clock loop should follow. Each channel carries a 4-bit priority from configuration and a validity flag from an external monitor. A channel is a candidate only when it is valid and its effective priority is nonzero. Among candidates, a smaller priority value wins. The block reports the chosen channel number and a ranked list of the best candidates. When nothing can be chosen, it raises a holdover request.

The channels are numbered from 1. The number 0 always means "no channel". The first channel pairs are two physical ports of one logical input, and only one port of a pair may take part in selection. A mode input picks revertive behaviour, where the selection always follows the best candidate, or non-revertive behaviour, where the selection stays on its current channel until that channel drops out. A 4-bit force field can pin the selection to one channel. All selection outputs are registered.

Top module: `ref_prio_select`

## Requirements
- R1: While rst_ni is low, sel_ch_o is 0, holdover_o is 1 and every rank_o field is 0.
- R2: A channel whose priority field is 0 is never selected automatically and never ranked. Among the candidates, a smaller priority value ranks higher. Channel k's priority occupies prio_i[4k-1:4k-4], and its flag is valid_i[k-1].
- R3: When candidates have equal priority, the lower channel number ranks first.
- R4: A channel whose valid_i bit is 0 is neither ranked nor selected automatically.
- R5: Channels 2p-1 and 2p form a pair for p = 1..NUM_PAIRS. When the priority of the odd-numbered port is nonzero, the even-numbered port is treated as having priority 0.
- R6: rank_o holds the channel numbers of the best RANK_N candidates in order, each CH_W bits wide, with the best candidate in the least significant field. Unused fields are 0.
- R7: When revert_i is 1 and no force is active, sel_ch_o equals the best candidate, which is the same value as the first rank_o field.
- R8: When revert_i is 0 and no force is active, sel_ch_o keeps its current nonzero channel while that channel is still a candidate. Otherwise it takes the best candidate.
- R9: A force_i value from 1 to NUM_CH selects that channel, regardless of its priority or validity. The values 0 and 4'hF, and any value above NUM_CH, mean automatic selection.
- R10: holdover_o is 1 exactly when sel_ch_o is 0, which happens when no force is active and no candidate exists.
- R11: Every output changes on the rising clock edge that follows an input change, and not earlier.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| prio_i | input | NUM_CH*4 | Per-channel priority, 0 disables the channel |
| valid_i | input | NUM_CH | Per-channel "no outstanding alarm" flag |
| revert_i | input | 1 | 1 selects revertive mode, 0 selects non-revertive mode |
| force_i | input | 4 | Forced channel number; 0, 4'hF or out-of-range values mean automatic |
| sel_ch_o | output | CH_W | Selected channel number, 0 when none |
| holdover_o | output | 1 | Holdover request |
| rank_o | output | RANK_N*CH_W | Ranked candidate channel numbers, best in the low field |

## Verification
The stimulus uses the following patterns, each aimed at one decision:
- Distinct priorities check that ordering follows the priority value and not the channel index.
- Equal priorities isolate the tie rule.
- Clearing one valid flag, or one priority in a pair, checks that both ways of dropping a channel out work.
- In non-revertive mode, a better channel appears while the current channel is still healthy, and later the current channel fails. This separates "stay" from "move".
- Force codes inside the range, at 0 and 4'hF, and above the channel count check that only legal codes take effect.
- An empty candidate set exercises the holdover request.

// File: rtl/ref_sel_pkg.sv
package ref_sel_pkg;
  localparam int unsigned PRIO_W  = 4;
  localparam int unsigned FORCE_W = 4;
  localparam logic [FORCE_W-1:0] FORCE_AUTO_LO = '0;
  localparam logic [FORCE_W-1:0] FORCE_AUTO_HI = '1;
endpackage

// File: rtl/ref_sel_pair_gate.sv
module ref_sel_pair_gate
  import ref_sel_pkg::*;
#(
  parameter int unsigned NUM_CH    = 5,
  parameter int unsigned NUM_PAIRS = 2
) (
  input  logic [NUM_CH*PRIO_W-1:0] prio_i,
  input  logic [NUM_CH-1:0]        valid_i,
  output logic [NUM_CH*PRIO_W-1:0] eff_prio_o,
  output logic [NUM_CH-1:0]        elig_o
);
  for (genvar c = 0; c < NUM_CH; c++) begin : g_ch
    logic [PRIO_W-1:0] own;
    assign own = prio_i[c*PRIO_W +: PRIO_W];
    if ((c % 2 == 1) && (c < 2*NUM_PAIRS)) begin : g_alt
      // alternate port is muted while its partner carries a priority
      logic partner_on;
      assign partner_on = |prio_i[(c-1)*PRIO_W +: PRIO_W];
      assign eff_prio_o[c*PRIO_W +: PRIO_W] = partner_on ? '0 : own;
    end else begin : g_solo
      assign eff_prio_o[c*PRIO_W +: PRIO_W] = own;
    end
    assign elig_o[c] = valid_i[c] && (|eff_prio_o[c*PRIO_W +: PRIO_W]);
  end
endmodule

// File: rtl/ref_sel_ranker.sv
module ref_sel_ranker
  import ref_sel_pkg::*;
#(
  parameter int unsigned NUM_CH = 5,
  parameter int unsigned CH_W   = 3,
  parameter int unsigned RANK_N = 3
) (
  input  logic [NUM_CH*PRIO_W-1:0] eff_prio_i,
  input  logic [NUM_CH-1:0]        elig_i,
  output logic [RANK_N*CH_W-1:0]   rank_o
);
  localparam int unsigned KEY_W = PRIO_W + CH_W;

  logic [NUM_CH-1:0] taken;
  logic [KEY_W-1:0]  best_key;
  logic [KEY_W-1:0]  key;
  logic [CH_W-1:0]   best_ch;
  logic              found;

  always_comb begin
    taken    = '0;
    rank_o   = '0;
    best_key = '0;
    best_ch  = '0;
    key      = '0;
    found    = 1'b0;
    for (int r = 0; r < RANK_N; r++) begin
      found    = 1'b0;
      best_key = '1;
      best_ch  = '0;
      for (int c = 0; c < NUM_CH; c++) begin
        // key orders by priority first, then by index
        key = {eff_prio_i[c*PRIO_W +: PRIO_W], CH_W'(c)};
        if (elig_i[c] && !taken[c] && (!found || key < best_key)) begin
          found    = 1'b1;
          best_key = key;
          best_ch  = CH_W'(c + 1);
        end
      end
      if (found) begin
        taken[best_ch - CH_W'(1)] = 1'b1;
        rank_o[r*CH_W +: CH_W]    = best_ch;
      end
    end
  end
endmodule

// File: rtl/ref_sel_decide.sv
module ref_sel_decide
  import ref_sel_pkg::*;
#(
  parameter int unsigned NUM_CH = 5,
  parameter int unsigned CH_W   = 3
) (
  input  logic [FORCE_W-1:0] force_i,
  input  logic               revert_i,
  input  logic [CH_W-1:0]    cur_sel_i,
  input  logic [NUM_CH-1:0]  elig_i,
  input  logic [CH_W-1:0]    top_i,
  output logic [CH_W-1:0]    next_sel_o
);
  logic force_hit;
  logic cur_ok;

  assign force_hit = (force_i != FORCE_AUTO_LO) && (force_i != FORCE_AUTO_HI) &&
                     (int'(force_i) <= int'(NUM_CH));

  always_comb begin
    cur_ok = 1'b0;
    for (int c = 0; c < NUM_CH; c++) begin
      if (cur_sel_i == CH_W'(c + 1)) cur_ok = elig_i[c];
    end
  end

  always_comb begin
    if (force_hit)                   next_sel_o = CH_W'(force_i);
    else if (revert_i)               next_sel_o = top_i;
    else if (cur_ok)                 next_sel_o = cur_sel_i;
    else                             next_sel_o = top_i;
  end
endmodule

// File: rtl/ref_prio_select.sv
module ref_prio_select
  import ref_sel_pkg::*;
#(
  parameter int unsigned NUM_CH    = 5,
  parameter int unsigned NUM_PAIRS = 2,
  parameter int unsigned RANK_N    = 3,
  parameter int unsigned CH_W      = $clog2(NUM_CH + 1)
) (
  input  logic                     clk_i,
  input  logic                     rst_ni,
  input  logic [NUM_CH*PRIO_W-1:0] prio_i,
  input  logic [NUM_CH-1:0]        valid_i,
  input  logic                     revert_i,
  input  logic [FORCE_W-1:0]       force_i,
  output logic [CH_W-1:0]          sel_ch_o,
  output logic                     holdover_o,
  output logic [RANK_N*CH_W-1:0]   rank_o
);
  logic [NUM_CH*PRIO_W-1:0] eff_prio;
  logic [NUM_CH-1:0]        elig;
  logic [RANK_N*CH_W-1:0]   rank_d;
  logic [CH_W-1:0]          sel_d;

  ref_sel_pair_gate #(.NUM_CH(NUM_CH), .NUM_PAIRS(NUM_PAIRS)) u_gate (
    .prio_i    (prio_i),
    .valid_i   (valid_i),
    .eff_prio_o(eff_prio),
    .elig_o    (elig)
  );

  ref_sel_ranker #(.NUM_CH(NUM_CH), .CH_W(CH_W), .RANK_N(RANK_N)) u_rank (
    .eff_prio_i(eff_prio),
    .elig_i    (elig),
    .rank_o    (rank_d)
  );

  ref_sel_decide #(.NUM_CH(NUM_CH), .CH_W(CH_W)) u_decide (
    .force_i   (force_i),
    .revert_i  (revert_i),
    .cur_sel_i (sel_ch_o),
    .elig_i    (elig),
    .top_i     (rank_d[CH_W-1:0]),
    .next_sel_o(sel_d)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      sel_ch_o   <= '0;
      holdover_o <= 1'b1;
      rank_o     <= '0;
    end else begin
      sel_ch_o   <= sel_d;
      holdover_o <= (sel_d == '0);
      rank_o     <= rank_d;
    end
  end
endmodule

// File: rtl/ref_sel_chk.sv
module ref_sel_chk
  import ref_sel_pkg::*;
#(
  parameter int unsigned NUM_CH    = 5,
  parameter int unsigned NUM_PAIRS = 2,
  parameter int unsigned RANK_N    = 3,
  parameter int unsigned CH_W      = $clog2(NUM_CH + 1)
) (
  input logic                     clk_i,
  input logic                     rst_ni,
  input logic [NUM_CH*PRIO_W-1:0] prio_i,
  input logic [NUM_CH-1:0]        valid_i,
  input logic                     revert_i,
  input logic [FORCE_W-1:0]       force_i,
  input logic [CH_W-1:0]          sel_ch_o,
  input logic                     holdover_o,
  input logic [RANK_N*CH_W-1:0]   rank_o
);
  logic                     armed;
  logic [NUM_CH*PRIO_W-1:0] pv_prio;
  logic [NUM_CH-1:0]        pv_valid;
  logic                     pv_revert;
  logic [FORCE_W-1:0]       pv_force;
  logic [CH_W-1:0]          pv_sel;
  logic                     pv_hit, pv_sel_valid, top_valid, top_prio_nz;
  logic [CH_W-1:0]          r1, r2;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      armed <= 1'b0; pv_prio <= '0; pv_valid <= '0;
      pv_revert <= 1'b0; pv_force <= '0; pv_sel <= '0;
    end else begin
      armed <= 1'b1; pv_prio <= prio_i; pv_valid <= valid_i;
      pv_revert <= revert_i; pv_force <= force_i; pv_sel <= sel_ch_o;
    end
  end

  assign pv_hit = (pv_force != '0) && (pv_force != '1) && (int'(pv_force) <= int'(NUM_CH));
  assign r1 = rank_o[CH_W-1:0];
  assign r2 = rank_o[(RANK_N > 1 ? 1 : 0)*CH_W +: CH_W];

  always_comb begin
    pv_sel_valid = 1'b0;
    top_valid    = 1'b0;
    top_prio_nz  = 1'b0;
    for (int c = 0; c < NUM_CH; c++) begin
      if (pv_sel == CH_W'(c + 1)) pv_sel_valid = pv_valid[c];
      if (r1 == CH_W'(c + 1)) begin
        top_valid   = pv_valid[c];
        top_prio_nz = |pv_prio[c*PRIO_W +: PRIO_W];
      end
    end
  end

  AST_HOLD_IFF_NONE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    holdover_o == (sel_ch_o == '0));                                        // R10
  AST_FORCE_WINS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (armed && pv_hit) |-> (sel_ch_o == CH_W'(pv_force)));                    // R9
  AST_REVERT_TOP: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (armed && pv_revert && !pv_hit) |-> (sel_ch_o == r1));                   // R7
  AST_NONREV_LEAVE_DEAD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (armed && !pv_revert && !pv_hit && pv_sel != '0 && !pv_sel_valid) |-> (sel_ch_o != pv_sel)); // R8
  AST_RANK_ORDER: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (r2 != '0) |-> (r1 != '0 && r1 != r2));                                  // R6
  AST_RANK_VALID: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (armed && r1 != '0) |-> top_valid);                                      // R4
  AST_ZERO_PRIO_OUT: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (armed && r1 != '0) |-> top_prio_nz);                                    // R2
endmodule

bind ref_prio_select ref_sel_chk #(
  .NUM_CH(NUM_CH), .NUM_PAIRS(NUM_PAIRS), .RANK_N(RANK_N), .CH_W(CH_W)
) u_chk (.*);

// File: tb/ref_prio_select_test.sv
module ref_prio_select_test;
  localparam int N  = 5;
  localparam int NP = 2;
  localparam int RN = 3;
  localparam int CW = 3;

  typedef struct packed {
    logic [CW-1:0]    sel;
    logic             hold;
    logic [RN*CW-1:0] rank;
  } exp_t;

  logic            clk_i = 1'b0;
  logic            rst_ni = 1'b0;
  logic [N*4-1:0]  prio_i = '0;
  logic [N-1:0]    valid_i = '0;
  logic            revert_i = 1'b1;
  logic [3:0]      force_i = '0;
  logic [CW-1:0]   sel_ch_o;
  logic            holdover_o;
  logic [RN*CW-1:0] rank_o;

  int n_chk = 0, n_bad = 0;
  exp_t  exp_q[$];
  string tag_q[$];
  logic [CW-1:0] m_sel = '0;

  always #4 clk_i = ~clk_i;

  ref_prio_select #(.NUM_CH(N), .NUM_PAIRS(NP), .RANK_N(RN)) uut (.*);

  function automatic logic [N*4-1:0] pk(input int a, b, c, d, e);
    return {4'(e), 4'(d), 4'(c), 4'(b), 4'(a)};
  endfunction

  // independent model: scan priority levels, then channels
  function automatic exp_t model(input logic [N*4-1:0] pr, input logic [N-1:0] v,
                                 input logic rv, input logic [3:0] f);
    exp_t e;
    int   eff[N];
    int   slot = 0;
    logic cur_ok = 1'b0;
    e = '0;
    for (int c = 0; c < N; c++) begin
      eff[c] = int'(pr[c*4 +: 4]);
      if (c % 2 == 1 && c < 2*NP && pr[(c-1)*4 +: 4] != 0) eff[c] = 0;
    end
    for (int p = 1; p < 16; p++)
      for (int c = 0; c < N; c++)
        if (v[c] && eff[c] == p && slot < RN) begin
          e.rank[slot*CW +: CW] = CW'(c + 1);
          slot++;
        end
    if (m_sel != 0) cur_ok = v[m_sel-1] && eff[m_sel-1] != 0;
    if (f >= 1 && f <= N)      e.sel = CW'(f);
    else if (rv || !cur_ok)    e.sel = e.rank[CW-1:0];
    else                       e.sel = m_sel;
    e.hold = (e.sel == 0);
    return e;
  endfunction

  task automatic drive(input logic [N*4-1:0] pr, input logic [N-1:0] v, input logic rv,
                       input logic [3:0] f, input string tag, input bit lat_chk = 1'b0);
    exp_t e;
    logic [CW-1:0] old;
    @(negedge clk_i);
    old = m_sel;
    prio_i = pr; valid_i = v; revert_i = rv; force_i = f;
    e = model(pr, v, rv, f);
    m_sel = e.sel;
    exp_q.push_back(e);
    tag_q.push_back(tag);
    if (lat_chk) begin
      #1;
      n_chk++;
      if (sel_ch_o !== old) begin
        n_bad++;
        $display("FAIL R11 early change: sel=%0d expected %0d", sel_ch_o, old);
      end
    end
  endtask

  initial begin : monitor
    exp_t  e;
    string t;
    forever begin
      @(posedge clk_i);
      if (exp_q.size() > 0) begin
        e = exp_q.pop_front();
        t = tag_q.pop_front();
        #2;
        n_chk++;
        if (sel_ch_o !== e.sel || holdover_o !== e.hold || rank_o !== e.rank) begin
          n_bad++;
          $display("FAIL %s: sel=%0d hold=%0b rank=%h expected sel=%0d hold=%0b rank=%h",
                   t, sel_ch_o, holdover_o, rank_o, e.sel, e.hold, e.rank);
        end
      end
    end
  end

  initial begin : watchdog
    #(8 * 200000);
    n_bad++; n_chk++;
    $display("FAIL watchdog expired");
    $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
    $finish;
  end

  initial begin : stim
    repeat (3) @(negedge clk_i);
    #1;
    n_chk++;
    if (sel_ch_o !== 0 || holdover_o !== 1'b1 || rank_o !== 0) begin
      n_bad++;
      $display("FAIL R1 reset: sel=%0d hold=%0b rank=%h expected 0 1 0", sel_ch_o, holdover_o, rank_o);
    end
    @(negedge clk_i); rst_ni = 1'b1;
    drive(pk(3,0,1,0,2), 5'b11111, 1, 0, "R2 priority order");
    drive(pk(2,0,2,0,2), 5'b11111, 1, 0, "R3 tie by index", 1'b1);
    drive(pk(2,0,2,0,2), 5'b11110, 1, 0, "R4 invalid excluded");
    drive(pk(1,1,0,5,0), 5'b11111, 1, 0, "R5 pair 1/2 exclusion");
    drive(pk(0,2,4,1,0), 5'b11111, 1, 0, "R5 pair 3/4 exclusion");
    drive(pk(0,2,1,0,0), 5'b11111, 0, 0, "R8 keep current");
    drive(pk(0,2,1,0,0), 5'b11101, 0, 0, "R8 leave failed source");
    drive(pk(0,1,3,0,0), 5'b11111, 0, 0, "R8 ignore better source");
    drive(pk(0,1,3,0,0), 5'b11111, 1, 0, "R7 revert to best");
    drive(pk(0,1,3,0,0), 5'b01111, 1, 4'd5, "R9 force disabled channel");
    drive(pk(0,1,3,0,0), 5'b11111, 1, 4'hF, "R9 all-ones auto");
    drive(pk(0,1,3,0,0), 5'b11111, 1, 4'd9, "R9 out-of-range auto");
    drive(pk(0,1,3,0,0), 5'b11111, 0, 4'd3, "R9 force in non-revertive");
    drive(pk(0,1,3,0,0), 5'b11111, 0, 4'd0, "R8 keep after force release");
    drive(pk(0,1,3,0,0), 5'b00000, 1, 0, "R10 holdover when empty");
    drive(pk(5,0,0,3,4), 5'b11111, 1, 0, "R6 three ranked");
    drive(pk(5,0,0,3,4), 5'b11111, 1, 0, "R11 steady");
    repeat (4) @(negedge clk_i);
    $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
    $finish;
  end
endmodule